// File: doc/BRIEF.md
# DDR SDRAM Power-Down Clock-Enable Sequencer

This block lives inside a DDR SDRAM memory controller and owns the clock-enable pin. It decides when the memory device may drop into its low-power state and when it has to come back out. It watches read and write commands as they issue. It keeps CKE high until every such access has fully drained. For a read, that means the postamble has ended. For a write, it means the write-recovery time has run out after the last data beat.

The block also watches an idle request from the command scheduler, which must stay high for a minimum run of cycles. It watches a refresh-due flag and a new-request flag; either one wakes the device at once. While the device is powered down, or is in its exit cycle, the command-slot grant stays low so that the scheduler holds off. On the exit cycle CKE is high and the bus carries only a NOP. A real command may follow one cycle later. When the device enters power-down, the block records whether any bank had an open row. This tells the rest of the controller whether the device is in precharge power-down or active power-down.

Top module: `ddr_pd_sequencer`

## Requirements
- R1: After reset, cke is 1, cmd_grant is 1 and pd_active_mode is 0.
- R2: cke falls at the clock edge that samples idle_req high for the MIN_IDLE-th consecutive time, provided nothing else blocks entry. A run of idle_req shorter than MIN_IDLE samples never lowers cke, and a low sample restarts the count.
- R3: A read issue sampled at edge k keeps cke high through edge k+RD_HOLD. The earliest edge at which cke can fall is k+RD_HOLD+1.
- R4: A write issue keeps cke high while that write has not seen its last data beat. A last-data beat sampled at edge m keeps cke high through edge m+TWR. The earliest edge at which cke can fall is m+TWR+1.
- R5: cmd_grant is 0 in every cycle in which cke is 0.
- R6: At the edge where cke falls, pd_active_mode takes the value 1 if any bit of bank_open is 1, and 0 otherwise. It then holds that value, whatever bank_open does, until the next entry.
- R7: When refresh_due or new_req is sampled high while cke is 0, cke is 1 after that same edge and cmd_grant stays 0 for that one exit cycle. cmd_grant returns to 1 at the following edge.
- R8: While refresh_due or new_req is high, cke stays 1 even if idle_req qualifies. These inputs do not restart the idle count: if idle_req has already qualified, cke falls at the first edge that samples both of them low.
- R9: A wake request sampled on the first cycle that cke is low, the entry cycle, also follows the exit sequence of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_issue | input | 1 | A READ command issues this cycle |
| wr_issue | input | 1 | A WRITE command issues this cycle |
| wr_last_data | input | 1 | Last data beat of the oldest outstanding write |
| bank_open | input | NUM_BANKS | One bit per bank, 1 while that bank has an open row |
| idle_req | input | 1 | Scheduler reports nothing to send |
| refresh_due | input | 1 | Refresh must be issued soon |
| new_req | input | 1 | Scheduler has new work |
| cke | output | 1 | Registered clock-enable to the device |
| cmd_grant | output | 1 | Scheduler may place a command this cycle |
| pd_active_mode | output | 1 | 1 when the current or latest power-down is the active kind |

## Verification
Each input acts at the edge that samples it, and every output comes straight from a register. CKE and the grant therefore change exactly one edge after the deciding sample, and the exit grant returns one edge after that. The bench drives inputs on the falling edge and reads outputs at the next falling edge. It counts edges from the start of an idle run until CKE falls. It compares that count with a bound computed in the bench: the larger of MIN_IDLE and the drain time of the access, which is the issue offset plus RD_HOLD plus two, or the issue offset plus the data gap plus TWR plus two. These bounds are checked across swept offsets, swept data gaps and all sixteen bank patterns.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_ENTER = 2'd1,
    PD_SLEEP = 2'd2,
    PD_WAKE  = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pd_rst_sync.sv
module pd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pd_access_tracker.sv
module pd_access_tracker #(
  parameter int RD_HOLD = 5,
  parameter int TWR     = 3,
  parameter int MAX_WR  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_issue,
  input  logic wr_issue,
  input  logic wr_last_data,
  output logic acc_busy
);
  localparam int RCW = $clog2(RD_HOLD + 1);
  localparam int WCW = $clog2(TWR + 1);
  localparam int PCW = $clog2(MAX_WR + 1);
  localparam logic [RCW-1:0] RD_LOAD = RCW'(RD_HOLD);
  localparam logic [WCW-1:0] WR_LOAD = WCW'(TWR);
  localparam logic [PCW-1:0] PEND_MAX = PCW'(MAX_WR);

  logic [RCW-1:0] rd_cnt_q, rd_cnt_d;
  logic [WCW-1:0] wr_cnt_q, wr_cnt_d;
  logic [PCW-1:0] pend_q, pend_d;
  logic           rd_cnt_en, wr_cnt_en, pend_en;

  // read drain counter: reload on issue, count down otherwise
  always_comb begin
    rd_cnt_en = rd_issue || (rd_cnt_q != '0);
    rd_cnt_d  = rd_issue ? RD_LOAD : rd_cnt_q - 1'b1;
  end

  // write recovery counter: reload on the last data beat
  always_comb begin
    wr_cnt_en = wr_last_data || (wr_cnt_q != '0);
    wr_cnt_d  = wr_last_data ? WR_LOAD : wr_cnt_q - 1'b1;
  end

  // writes waiting for their last data beat
  always_comb begin
    pend_en = wr_issue ^ (wr_last_data && (pend_q != '0));
    pend_d  = pend_q;
    if (wr_issue && !(wr_last_data && (pend_q != '0))) begin
      if (pend_q != PEND_MAX) pend_d = pend_q + 1'b1;
    end else if (!wr_issue && wr_last_data && (pend_q != '0)) begin
      pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt_q <= '0;
      wr_cnt_q <= '0;
      pend_q   <= '0;
    end else begin
      if (rd_cnt_en) rd_cnt_q <= rd_cnt_d;
      if (wr_cnt_en) wr_cnt_q <= wr_cnt_d;
      if (pend_en)   pend_q   <= pend_d;
    end
  end

  assign acc_busy = rd_issue || wr_issue || wr_last_data ||
                    (rd_cnt_q != '0) || (wr_cnt_q != '0) || (pend_q != '0);

  // R3
  rd_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> (rd_cnt_q != '0));

  // R4
  wr_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last_data |=> (wr_cnt_q != '0));
endmodule

// File: rtl/pd_idle_qual.sv
module pd_idle_qual #(
  parameter int MIN_IDLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_state,
  input  logic idle_req,
  output logic idle_ok
);
  localparam int CW = (MIN_IDLE > 1) ? $clog2(MIN_IDLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_IDLE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!run_state || !idle_req) cnt_d = '0;
    else if (cnt_q != LAST)      cnt_d = cnt_q + 1'b1;
    else begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign idle_ok = run_state && idle_req && (cnt_q == LAST);

  // R2
  idle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(idle_req));
endmodule

// File: rtl/pd_cke_fsm.sv
module pd_cke_fsm
  import pd_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idle_ok,
  input  logic                 acc_busy,
  input  logic                 wake,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic                 run_state,
  output logic                 cke,
  output logic                 cmd_grant,
  output logic                 pd_active_mode
);
  pd_state_e state_q, state_d;
  logic      cke_q, cke_d;
  logic      mode_q;
  logic      mode_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PD_RUN:   if (idle_ok && !acc_busy && !wake) state_d = PD_ENTER;
      PD_ENTER: state_d = wake ? PD_WAKE : PD_SLEEP;
      PD_SLEEP: if (wake) state_d = PD_WAKE;
      PD_WAKE:  state_d = PD_RUN;
      default:  state_d = PD_RUN;
    endcase
    cke_d   = (state_d == PD_RUN) || (state_d == PD_WAKE);
    mode_en = (state_q == PD_RUN) && (state_d == PD_ENTER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_RUN;
      cke_q   <= 1'b1;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cke_q   <= cke_d;
      if (mode_en) mode_q <= |bank_open;
    end
  end

  assign run_state      = (state_q == PD_RUN);
  assign cke            = cke_q;
  assign cmd_grant      = (state_q == PD_RUN);
  assign pd_active_mode = mode_q;

  // R5
  grant_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_grant |-> cke_q);

  // R7
  exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_q) |-> !cmd_grant);

  // R7
  exit_then_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_q) |=> cmd_grant);

  // R9
  entry_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_ENTER) |=> (state_q != PD_RUN));
endmodule

// File: rtl/ddr_pd_sequencer.sv
module ddr_pd_sequencer #(
  parameter int NUM_BANKS = 4,
  parameter int RD_HOLD   = 5,
  parameter int TWR       = 3,
  parameter int MIN_IDLE  = 4,
  parameter int MAX_WR    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_issue,
  input  logic                 wr_issue,
  input  logic                 wr_last_data,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 idle_req,
  input  logic                 refresh_due,
  input  logic                 new_req,
  output logic                 cke,
  output logic                 cmd_grant,
  output logic                 pd_active_mode
);
  logic rst_n_s;
  logic acc_busy;
  logic idle_ok;
  logic run_state;
  logic wake;

  assign wake = refresh_due || new_req;

  pd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pd_access_tracker #(
    .RD_HOLD (RD_HOLD),
    .TWR     (TWR),
    .MAX_WR  (MAX_WR)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .rd_issue     (rd_issue),
    .wr_issue     (wr_issue),
    .wr_last_data (wr_last_data),
    .acc_busy     (acc_busy)
  );

  pd_idle_qual #(
    .MIN_IDLE (MIN_IDLE)
  ) u_idle (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_state (run_state),
    .idle_req  (idle_req),
    .idle_ok   (idle_ok)
  );

  pd_cke_fsm #(
    .NUM_BANKS (NUM_BANKS)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .idle_ok        (idle_ok),
    .acc_busy       (acc_busy),
    .wake           (wake),
    .bank_open      (bank_open),
    .run_state      (run_state),
    .cke            (cke),
    .cmd_grant      (cmd_grant),
    .pd_active_mode (pd_active_mode)
  );

  // R3
  // R4
  no_cut_access_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(cke) |-> $past(!acc_busy));

  // R8
  wake_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(cke) |-> $past(!wake));

  // R7
  wake_raises_cke_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cke && wake) |=> cke);

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cke && $past(!cke)) |-> $stable(pd_active_mode));
endmodule

// File: tb/ddr_pd_sequencer_test.sv
module ddr_pd_sequencer_test;
  localparam int NB  = 4;
  localparam int RDH = 5;
  localparam int TW  = 3;
  localparam int MI  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_issue = 1'b0, wr_issue = 1'b0, wr_last_data = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic          idle_req = 1'b0, refresh_due = 1'b0, new_req = 1'b0;
  logic          cke, cmd_grant, pd_active_mode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ddr_pd_sequencer #(
    .NUM_BANKS (NB), .RD_HOLD (RDH), .TWR (TW), .MIN_IDLE (MI), .MAX_WR (4)
  ) uut (
    .clk (clk), .rst_n (rst_n), .rd_issue (rd_issue), .wr_issue (wr_issue),
    .wr_last_data (wr_last_data), .bank_open (bank_open), .idle_req (idle_req),
    .refresh_due (refresh_due), .new_req (new_req), .cke (cke),
    .cmd_grant (cmd_grant), .pd_active_mode (pd_active_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // kind 0: idle only, 1: read at offset d, 2: write at offset d with data gap g
  task automatic measure(input int kind, input int d, input int g, output int n);
    n = 0;
    idle_req = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      rd_issue     = (kind == 1) && (k == d + 1);
      wr_issue     = (kind == 2) && (k == d + 1);
      wr_last_data = (kind == 2) && (k == d + 1 + g);
      step();
      if (!cke) begin
        n = k;
        break;
      end
    end
    rd_issue = 1'b0; wr_issue = 1'b0; wr_last_data = 1'b0;
    idle_req = 1'b0;
  endtask

  task automatic wake_up(input bit use_refresh, input string req);
    if (use_refresh) refresh_due = 1'b1; else new_req = 1'b1;
    step();
    refresh_due = 1'b0; new_req = 1'b0;
    chk({req, " exit cke"}, int'(cke), 1);
    chk({req, " exit grant"}, int'(cmd_grant), 0);
    step();
    chk({req, " grant after exit"}, int'(cmd_grant), 1);
    step();
  endtask

  initial begin
    int n;
    int exp;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1
    chk("R1 cke", int'(cke), 1);
    chk("R1 grant", int'(cmd_grant), 1);
    chk("R1 mode", int'(pd_active_mode), 0);

    // R2: runs too short never enter
    for (int len = 1; len < MI; len++) begin
      idle_req = 1'b1;
      for (int k = 0; k < len; k++) begin
        step();
        chk("R2 short run cke", int'(cke), 1);
      end
      idle_req = 1'b0;
      step();
      chk("R2 after short run", int'(cke), 1);
    end
    // R2 / R5: exact entry edge
    measure(0, 0, 0, n);
    chk("R2 entry edge", n, MI);
    chk("R5 grant while low", int'(cmd_grant), 0);
    step();
    chk("R5 grant while sleeping", int'(cmd_grant), 0);
    wake_up(1'b0, "R7");

    // R3: read issue at offset d
    for (int d = 0; d < 4; d++) begin
      measure(1, d, 0, n);
      exp = (d + RDH + 2 > MI) ? d + RDH + 2 : MI;
      chk("R3 read drain entry edge", n, exp);
      wake_up(1'b1, "R7");
    end

    // R4: write at offset d, last data after gap g
    for (int d = 0; d < 3; d++) begin
      for (int g = 1; g <= 3; g++) begin
        measure(2, d, g, n);
        exp = (d + g + TW + 2 > MI) ? d + g + TW + 2 : MI;
        chk("R4 write recovery entry edge", n, exp);
        wake_up(1'b0, "R7");
      end
    end

    // R6: every bank pattern
    for (int b = 0; b < (1 << NB); b++) begin
      bank_open = NB'(b);
      measure(0, 0, 0, n);
      chk("R6 entry edge", n, MI);
      chk("R6 mode at entry", int'(pd_active_mode), (b != 0) ? 1 : 0);
      bank_open = ~NB'(b);
      step();
      step();
      chk("R6 mode held", int'(pd_active_mode), (b != 0) ? 1 : 0);
      wake_up(b[0], "R7");
      chk("R6 mode after exit", int'(pd_active_mode), (b != 0) ? 1 : 0);
    end
    bank_open = '0;

    // R8: wake inputs block entry without restarting the count
    for (int which = 0; which < 2; which++) begin
      idle_req = 1'b1;
      if (which == 0) refresh_due = 1'b1; else new_req = 1'b1;
      for (int k = 0; k < MI + 3; k++) begin
        step();
        chk("R8 blocked cke", int'(cke), 1);
      end
      refresh_due = 1'b0; new_req = 1'b0;
      step();
      chk("R8 entry right after release", int'(cke), 0);
      idle_req = 1'b0;
      wake_up(which == 0, "R7");
    end

    // R9: wake in the entry cycle
    measure(0, 0, 0, n);
    chk("R9 entry edge", n, MI);
    wake_up(1'b0, "R9");
    wake_up_check_idle: begin
      chk("R9 back to run cke", int'(cke), 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule